// File: doc/BRIEF.md
# Soft-Start and Fault-Stop Supervisor

This block sits on the primary side of an isolated bridge converter controller and decides when the converter may switch, how it ramps up and how it winds down. It keeps two digital integrators. The primary soft-start level limits the duty cycle of the main switches. The rectifier soft-start level sets the on-time of the secondary synchronous rectifiers, which grow by leading-edge modulation. Both levels are presented to the gate sequencer, together with a drive enable and a rectifier enable.

Its inputs are comparator flags: the two line-undervoltage levels, overvoltage, the two bias-rail health flags, two temperature comparators, a flag that says the feedback loop owns the duty cycle, a restart request from the overload timer, and a strap that forbids gentle stops. Every flag passes a two-stage synchronizer first. A line drop into standby or an overload restart request normally winds the rectifier level down gently, at three or six times the charge rate. Overvoltage, a bias-rail undervoltage and an over-temperature condition stop everything at once, and so does any stop request when the strap is set.

Top module: `softstart_supervisor`

## Requirements
- R1: `mode` is 0 (off) while `uvlo_above_off` is low and 1 (standby) while it is high and `uvlo_above_run` is low. In both modes `drive_enable` and `sr_enable` are low and both levels are 0.
- R2: The primary level stays at 0 unless `vcc_good`, `ref_good` and `uvlo_above_run` are all high. Clearing any one of them keeps it at 0.
- R3: In mode 2 (run), `drive_enable` is high and `ss_level` rises by CHG_STEP on every clock.
- R4: `sr_level` starts to rise only after `ss_level` has been above LVL_GATE while `loop_in_ctl` was high. With `loop_in_ctl` low it stays at 0.
- R5: `sr_enable` is high exactly when `sr_level` is above LVL_OFS in mode 2 or mode 3.
- R6: In mode 3 (soft-stop), `sr_level` falls by 3*CHG_STEP per clock after a drop of `uvlo_above_run`, and by 6*CHG_STEP per clock while a restart request is or was present. While `hiccup_req` stays high after the stop, the block waits in mode 1.
- R7: During soft-stop `ss_level` holds and `drive_enable` stays high. On the clock after `sr_level` is seen at or below LVL_OFS, both levels become 0 and `mode` becomes 1.
- R8: `ovp_trip` high, `vcc_good` low or `ref_good` low gives mode 4 (fault), with both levels at 0 and both enables low. The block restarts from zero once the fault is gone.
- R9: With `soft_stop_off` high, a line drop or a restart request clears both levels and lowers `drive_enable` at once (mode 1) instead of entering mode 3.
- R10: Both levels saturate at 2^ACC_W-1 and never wrap.
- R11: Over-temperature asserts when `temp_hot` is high and releases only when `temp_warm` is low. While asserted the block is in mode 4. After release it starts again from zero.
- R12: A flag change driven between edges has no effect at the first two rising edges and takes effect at the third. The temperature latch adds one more edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo_above_off | input | 1 | Line above the shutdown level |
| uvlo_above_run | input | 1 | Line above the run level |
| ovp_trip | input | 1 | Overvoltage comparator |
| vcc_good | input | 1 | Gate-drive rail above its undervoltage level |
| ref_good | input | 1 | Reference rail above its undervoltage level |
| temp_hot | input | 1 | Die temperature above the trip point |
| temp_warm | input | 1 | Die temperature above the release point |
| loop_in_ctl | input | 1 | Feedback loop owns the duty cycle |
| hiccup_req | input | 1 | Overload restart request |
| soft_stop_off | input | 1 | Strap: every stop is immediate |
| ss_level | output | ACC_W | Primary soft-start level |
| sr_level | output | ACC_W | Rectifier soft-start level |
| sr_enable | output | 1 | Rectifier drive permitted |
| drive_enable | output | 1 | Primary gate drive permitted |
| mode | output | 3 | 0 off, 1 standby, 2 run, 3 soft-stop, 4 fault |

## Verification
The bench builds the block with ACC_W=6, CHG_STEP=1, LVL_OFS=10 and LVL_GATE=20. With these values a full ramp to saturation takes 63 clocks, so every ramp value can be compared against its arithmetic prediction. Soft-stops at both rates run from full scale down through the threshold, and the exact crossing step is checked. The small levels also make each fault source, the strap, the temperature hysteresis and the synchronizer latency affordable to visit from a saturated run state.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [2:0] {
        MODE_OFF   = 3'd0,
        MODE_WAIT  = 3'd1,
        MODE_RUN   = 3'd2,
        MODE_STOP  = 3'd3,
        MODE_FAULT = 3'd4
    } sup_mode_e;

    // synchronised comparator flags; field order matches the top-level packing
    typedef struct packed {
        logic uvlo_on;
        logic uvlo_run;
        logic ovp;
        logic vcc_ok;
        logic ref_ok;
        logic t_hot;
        logic t_warm;
        logic comp_ctl;
        logic hiccup;
        logic ssoff;
    } sup_flags_t;

    localparam int NFLAGS = $bits(sup_flags_t);

    // integrator command
    typedef struct packed {
        logic clr;
        logic up;
        logic dn;
        logic fast;
    } acc_cmd_t;

    localparam acc_cmd_t CMD_IDLE  = '{clr: 1'b0, up: 1'b0, dn: 1'b0, fast: 1'b0};
    localparam acc_cmd_t CMD_CLEAR = '{clr: 1'b1, up: 1'b0, dn: 1'b0, fast: 1'b0};

    localparam int SOFT_MULT = 3;
    localparam int FAST_MULT = 6;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int N      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sup_accum.sv
module sup_accum
    import sup_pkg::*;
#(
    parameter int W       = 10,
    parameter int UP      = 2,
    parameter int DN_SLOW = 6,
    parameter int DN_FAST = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  acc_cmd_t       cmd,
    output logic [W-1:0]   acc
);
    localparam logic [W:0] FULL = {1'b0, {W{1'b1}}};
    localparam logic [W:0] UPV  = (W+1)'(UP);
    localparam logic [W:0] DNS  = (W+1)'(DN_SLOW);
    localparam logic [W:0] DNF  = (W+1)'(DN_FAST);

    logic [W:0] wide, sum, up_val, step, dn_val;

    always_comb begin
        wide   = {1'b0, acc};
        sum    = wide + UPV;
        up_val = (sum > FULL) ? FULL : sum;
        step   = cmd.fast ? DNF : DNS;
        dn_val = (wide < step) ? '0 : (wide - step);
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clr) acc <= '0;
        else if (cmd.dn)    acc <= dn_val[W-1:0];
        else if (cmd.up)    acc <= up_val[W-1:0];
    end
endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
    import sup_pkg::*;
#(
    parameter int ACC_W    = 10,
    parameter int LVL_OFS  = 200,
    parameter int LVL_GATE = 400
) (
    input  logic             clk,
    input  logic             rst,
    input  sup_flags_t       f,
    input  logic [ACC_W-1:0] ss_acc,
    input  logic [ACC_W-1:0] sr_acc,
    output sup_mode_e        mode,
    output acc_cmd_t         ss_cmd,
    output acc_cmd_t         sr_cmd
);
    localparam logic [ACC_W-1:0] OFS_V  = ACC_W'(LVL_OFS);
    localparam logic [ACC_W-1:0] GATE_V = ACC_W'(LVL_GATE);

    sup_mode_e state, nxt;
    logic      therm;
    logic      sr_rel, rel_nxt;
    logic      fast, fast_nxt;
    logic      hard, start_ok, stop_req;

    // thermal latch: trip at the hot comparator, release below the warm one
    always_ff @(posedge clk) begin
        if (rst)            therm <= 1'b0;
        else if (f.t_hot)   therm <= 1'b1;
        else if (!f.t_warm) therm <= 1'b0;
    end

    always_comb begin
        hard     = f.ovp | ~f.vcc_ok | ~f.ref_ok | therm;
        start_ok = f.uvlo_run & ~f.hiccup;
        stop_req = ~f.uvlo_run | f.hiccup;
        nxt      = state;
        ss_cmd   = CMD_IDLE;
        sr_cmd   = CMD_IDLE;
        rel_nxt  = sr_rel;
        fast_nxt = fast;

        if (!f.uvlo_on) begin
            nxt = MODE_OFF;   ss_cmd = CMD_CLEAR; sr_cmd = CMD_CLEAR;
            rel_nxt = 1'b0;   fast_nxt = 1'b0;
        end else if (hard) begin
            nxt = MODE_FAULT; ss_cmd = CMD_CLEAR; sr_cmd = CMD_CLEAR;
            rel_nxt = 1'b0;   fast_nxt = 1'b0;
        end else begin
            unique case (state)
                MODE_RUN: begin
                    if (stop_req) begin
                        if (f.ssoff) begin
                            nxt = MODE_WAIT; ss_cmd = CMD_CLEAR; sr_cmd = CMD_CLEAR;
                            rel_nxt = 1'b0;
                        end else begin
                            nxt = MODE_STOP;
                            fast_nxt = f.hiccup;
                        end
                    end else begin
                        ss_cmd.up = 1'b1;
                        sr_cmd.up = sr_rel;
                        if ((ss_acc > GATE_V) && f.comp_ctl) rel_nxt = 1'b1;
                    end
                end
                MODE_STOP: begin
                    if (f.ssoff || (sr_acc <= OFS_V)) begin
                        nxt = MODE_WAIT; ss_cmd = CMD_CLEAR; sr_cmd = CMD_CLEAR;
                        rel_nxt = 1'b0;  fast_nxt = 1'b0;
                    end else begin
                        sr_cmd.dn   = 1'b1;
                        sr_cmd.fast = fast | f.hiccup;
                        fast_nxt    = fast | f.hiccup;
                    end
                end
                default: begin
                    ss_cmd = CMD_CLEAR; sr_cmd = CMD_CLEAR;
                    rel_nxt = 1'b0;     fast_nxt = 1'b0;
                    nxt = start_ok ? MODE_RUN : MODE_WAIT;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= MODE_OFF;
            sr_rel <= 1'b0;
            fast   <= 1'b0;
        end else begin
            state  <= nxt;
            sr_rel <= rel_nxt;
            fast   <= fast_nxt;
        end
    end

    assign mode = state;
endmodule

// File: rtl/softstart_supervisor.sv
module softstart_supervisor
    import sup_pkg::*;
#(
    parameter int ACC_W    = 10,
    parameter int CHG_STEP = 2,
    parameter int LVL_OFS  = 200,
    parameter int LVL_GATE = 400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             uvlo_above_off,
    input  logic             uvlo_above_run,
    input  logic             ovp_trip,
    input  logic             vcc_good,
    input  logic             ref_good,
    input  logic             temp_hot,
    input  logic             temp_warm,
    input  logic             loop_in_ctl,
    input  logic             hiccup_req,
    input  logic             soft_stop_off,
    output logic [ACC_W-1:0] ss_level,
    output logic [ACC_W-1:0] sr_level,
    output logic             sr_enable,
    output logic             drive_enable,
    output logic [2:0]       mode
);
    localparam int SLOW_DN = SOFT_MULT * CHG_STEP;
    localparam int FAST_DN = FAST_MULT * CHG_STEP;
    localparam logic [ACC_W-1:0] OFS_V = ACC_W'(LVL_OFS);

    logic [NFLAGS-1:0] raw_vec, sync_vec;
    sup_flags_t        flags;
    sup_mode_e         st;
    acc_cmd_t          ss_cmd, sr_cmd;
    logic              active;

    assign raw_vec = {uvlo_above_off, uvlo_above_run, ovp_trip, vcc_good, ref_good,
                      temp_hot, temp_warm, loop_in_ctl, hiccup_req, soft_stop_off};

    sup_sync #(.N(NFLAGS), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_vec),
        .q   (sync_vec)
    );

    assign flags = sup_flags_t'(sync_vec);

    sup_ctrl #(.ACC_W(ACC_W), .LVL_OFS(LVL_OFS), .LVL_GATE(LVL_GATE)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .f      (flags),
        .ss_acc (ss_level),
        .sr_acc (sr_level),
        .mode   (st),
        .ss_cmd (ss_cmd),
        .sr_cmd (sr_cmd)
    );

    sup_accum #(.W(ACC_W), .UP(CHG_STEP), .DN_SLOW(SLOW_DN), .DN_FAST(FAST_DN)) u_ss (
        .clk (clk),
        .rst (rst),
        .cmd (ss_cmd),
        .acc (ss_level)
    );

    sup_accum #(.W(ACC_W), .UP(CHG_STEP), .DN_SLOW(SLOW_DN), .DN_FAST(FAST_DN)) u_sr (
        .clk (clk),
        .rst (rst),
        .cmd (sr_cmd),
        .acc (sr_level)
    );

    assign active       = (st == MODE_RUN) || (st == MODE_STOP);
    assign drive_enable = active;
    assign sr_enable    = active && (sr_level > OFS_V);
    assign mode         = st;
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
    parameter int ACC_W    = 10,
    parameter int CHG_STEP = 2,
    parameter int LVL_OFS  = 200,
    parameter int LVL_GATE = 400
) (
    input logic             clk,
    input logic             rst,
    input logic             ovp_trip,
    input logic [ACC_W-1:0] ss_level,
    input logic [ACC_W-1:0] sr_level,
    input logic             sr_enable,
    input logic             drive_enable,
    input logic [2:0]       mode
);
    localparam logic [ACC_W-1:0] OFS_V  = ACC_W'(LVL_OFS);
    localparam logic [ACC_W-1:0] GATE_V = ACC_W'(LVL_GATE);
    localparam logic [ACC_W-1:0] SOFT_V = ACC_W'(3 * CHG_STEP);
    localparam logic [ACC_W-1:0] FAST_V = ACC_W'(6 * CHG_STEP);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0 || mode == 3'd1) |-> (!drive_enable && ss_level == '0 && sr_level == '0));

    a_r4_sr_gate: assert property (@(posedge clk) disable iff (rst)
        (sr_level != '0 && $past(sr_level) == '0) |-> ($past(ss_level) > GATE_V));

    a_r5_sr_enable: assert property (@(posedge clk) disable iff (rst)
        sr_enable |-> (sr_level > OFS_V && drive_enable));

    a_r6_stop_rate: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd3 && $past(mode) == 3'd3) |->
            (($past(sr_level) - sr_level) == SOFT_V || ($past(sr_level) - sr_level) == FAST_V
             || sr_level == '0));

    a_r7_ss_hold: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd3 && $past(mode) == 3'd3) |-> $stable(ss_level));

    a_r8_hard_stop: assert property (@(posedge clk) disable iff (rst)
        ($past(ovp_trip, 1) && $past(ovp_trip, 2) && $past(ovp_trip, 3)) |->
            (!drive_enable && ss_level == '0 && sr_level == '0));

    a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (ss_level >= $past(ss_level)) || (ss_level == '0));
endmodule

bind softstart_supervisor sup_checker #(
    .ACC_W(ACC_W), .CHG_STEP(CHG_STEP), .LVL_OFS(LVL_OFS), .LVL_GATE(LVL_GATE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ovp_trip     (ovp_trip),
    .ss_level     (ss_level),
    .sr_level     (sr_level),
    .sr_enable    (sr_enable),
    .drive_enable (drive_enable),
    .mode         (mode)
);

// File: tb/tb_softstart_supervisor.sv
`timescale 1ns/1ps
module tb_softstart_supervisor;
    localparam int W    = 6;
    localparam int C    = 1;
    localparam int OFS  = 10;
    localparam int GATE = 20;
    localparam int FULL = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic uvlo_above_off = 0, uvlo_above_run = 0, ovp_trip = 0, vcc_good = 0, ref_good = 0;
    logic temp_hot = 0, temp_warm = 0, loop_in_ctl = 0, hiccup_req = 0, soft_stop_off = 0;
    logic [W-1:0] ss_level, sr_level;
    logic sr_enable, drive_enable;
    logic [2:0] mode;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    softstart_supervisor #(.ACC_W(W), .CHG_STEP(C), .LVL_OFS(OFS), .LVL_GATE(GATE)) dut (
        .clk(clk), .rst(rst),
        .uvlo_above_off(uvlo_above_off), .uvlo_above_run(uvlo_above_run),
        .ovp_trip(ovp_trip), .vcc_good(vcc_good), .ref_good(ref_good),
        .temp_hot(temp_hot), .temp_warm(temp_warm), .loop_in_ctl(loop_in_ctl),
        .hiccup_req(hiccup_req), .soft_stop_off(soft_stop_off),
        .ss_level(ss_level), .sr_level(sr_level), .sr_enable(sr_enable),
        .drive_enable(drive_enable), .mode(mode)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic quiet(string req);
        chk(!drive_enable && !sr_enable, req, "enables low", {drive_enable, sr_enable}, 0);
        chk(ss_level == 0 && sr_level == 0, req, "levels zero", ss_level + sr_level, 0);
    endtask

    task automatic run_to_full();
        uvlo_above_run = 1; loop_in_ctl = 1;
        for (int i = 0; i < 300; i++) begin
            if (ss_level == FULL && sr_level == FULL) break;
            tick(1);
        end
        chk(ss_level == FULL && sr_level == FULL, "R10", "saturated run", sr_level, FULL);
    endtask

    task automatic soft_stop_sweep(int step, string req);
        int prev;
        for (int i = 0; i < 40; i++) begin
            prev = sr_level;
            tick(1);
            if (mode == 3'd3) begin
                chk(sr_level == ((prev > step) ? prev - step : 0), req, "stop step", sr_level,
                    (prev > step) ? prev - step : 0);
                chk(ss_level == FULL && drive_enable, "R7", "ss held", ss_level, FULL);
                chk(sr_enable == (sr_level > OFS), "R5", "sr_enable", sr_enable, sr_level > OFS);
            end else begin
                chk(prev <= OFS, "R7", "exit level", prev, OFS);
                chk(mode == 3'd1, "R7", "mode after stop", mode, 1);
                quiet("R7");
                break;
            end
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int prev;
        tick(3);
        chk(mode == 3'd0, "R1", "mode in reset", mode, 0);
        quiet("R1");
        rst = 0;
        tick(2);
        chk(mode == 3'd0, "R1", "mode off", mode, 0);
        quiet("R1");

        // standby and back to off
        uvlo_above_off = 1; vcc_good = 1; ref_good = 1;
        tick(4);
        chk(mode == 3'd1, "R1", "standby", mode, 1);
        quiet("R1");
        uvlo_above_off = 0;
        tick(4);
        chk(mode == 3'd0, "R1", "off again", mode, 0);
        uvlo_above_off = 1;

        // R2: each start condition missing
        for (int k = 0; k < 3; k++) begin
            uvlo_above_run = (k != 2); vcc_good = (k != 0); ref_good = (k != 1);
            tick(8);
            chk(ss_level == 0 && !drive_enable, "R2", "start gated", ss_level, 0);
        end
        uvlo_above_run = 0; vcc_good = 1; ref_good = 1;
        tick(4);

        // R3 ramp with loop not in control (R4)
        loop_in_ctl = 0; uvlo_above_run = 1;
        for (int i = 0; i < 10 && mode != 3'd2; i++) tick(1);
        chk(mode == 3'd2 && drive_enable, "R3", "run mode", mode, 2);
        for (int i = 0; i < 70; i++) begin
            prev = ss_level;
            tick(1);
            chk(ss_level == ((prev + C > FULL) ? FULL : prev + C), "R3", "ramp step", ss_level,
                (prev + C > FULL) ? FULL : prev + C);
            chk(sr_level == 0, "R4", "sr held without loop", sr_level, 0);
        end
        chk(ss_level == FULL, "R10", "ss saturates", ss_level, FULL);

        // R4/R5 release with loop in control
        loop_in_ctl = 1;
        for (int i = 0; i < 80; i++) begin
            prev = sr_level;
            tick(1);
            chk(sr_level >= prev && sr_level - prev <= C, "R4", "sr ramp", sr_level, prev + C);
            chk(sr_enable == (sr_level > OFS), "R5", "sr_enable", sr_enable, sr_level > OFS);
        end
        chk(sr_level == FULL, "R10", "sr saturates", sr_level, FULL);

        // fresh start with loop in control: sr waits for ss above gate
        uvlo_above_off = 0; tick(4); uvlo_above_off = 1;
        for (int i = 0; i < 60; i++) begin
            tick(1);
            if (sr_level != 0) chk(ss_level > GATE + 1, "R4", "gate level", ss_level, GATE + 2);
        end

        // R6 soft-stop from line drop, with R12 latency
        run_to_full();
        uvlo_above_run = 0;
        tick(2);
        chk(mode == 3'd2, "R12", "no effect at edge two", mode, 2);
        tick(1);
        chk(mode == 3'd3 && sr_level == FULL, "R6", "enter soft-stop", mode, 3);
        soft_stop_sweep(3 * C, "R6");

        // R6 soft-stop from restart request, then waiting
        uvlo_above_run = 1;
        run_to_full();
        hiccup_req = 1;
        tick(3);
        chk(mode == 3'd3, "R6", "hiccup stop", mode, 3);
        soft_stop_sweep(6 * C, "R6");
        tick(10);
        chk(mode == 3'd1, "R6", "wait while requested", mode, 1);
        quiet("R6");
        hiccup_req = 0;
        tick(4);
        chk(mode == 3'd2, "R6", "restart after request", mode, 2);

        // R9 strap turns stops into hard stops
        soft_stop_off = 1;
        run_to_full();
        uvlo_above_run = 0;
        tick(3);
        chk(mode == 3'd1, "R9", "strap line drop", mode, 1);
        quiet("R9");
        uvlo_above_run = 1;
        run_to_full();
        hiccup_req = 1;
        tick(3);
        chk(mode == 3'd1, "R9", "strap hiccup", mode, 1);
        quiet("R9");
        hiccup_req = 0; soft_stop_off = 0;

        // R8 hard faults
        for (int k = 0; k < 3; k++) begin
            run_to_full();
            if (k == 0) ovp_trip = 1; else if (k == 1) vcc_good = 0; else ref_good = 0;
            tick(2);
            chk(drive_enable, "R12", "fault not yet seen", drive_enable, 1);
            tick(1);
            chk(mode == 3'd4, "R8", "fault mode", mode, 4);
            quiet("R8");
            ovp_trip = 0; vcc_good = 1; ref_good = 1;
            tick(4);
            chk(mode == 3'd2 && ss_level <= 2, "R8", "restart from zero", ss_level, 1);
        end

        // R8 hard fault during soft-stop
        run_to_full();
        uvlo_above_run = 0;
        tick(5);
        chk(mode == 3'd3, "R8", "in soft-stop", mode, 3);
        ovp_trip = 1;
        tick(3);
        chk(mode == 3'd4, "R8", "fault over soft-stop", mode, 4);
        quiet("R8");
        ovp_trip = 0; uvlo_above_run = 1;

        // R11 thermal hysteresis
        run_to_full();
        temp_hot = 1; temp_warm = 1;
        tick(3);
        chk(mode == 3'd2, "R12", "thermal latch delay", mode, 2);
        tick(1);
        chk(mode == 3'd4, "R11", "thermal trip", mode, 4);
        temp_hot = 0;
        tick(10);
        chk(mode == 3'd4, "R11", "held between levels", mode, 4);
        quiet("R11");
        temp_warm = 0;
        tick(6);
        chk(mode == 3'd2 && ss_level <= 3, "R11", "restart after cool", ss_level, 2);

        done = 1;
        finish_run();
    end
endmodule